// File: doc/BRIEF.md
# Sleep Status Flag Register

This block is a 32-bit status register inside a power manager. It notes how the chip last went to sleep and which supply faults were seen, and it holds the GPIO input-disable and pad-hold conditions until software releases them. Five flags live in the register. Each one has its own set rule, and software clears a flag by writing a one to it.

Sleep can start in two ways: a one-cycle software request pulse, or a falling edge on the active-low VDD fault pin. A small sequencer remembers which of the two started the current sleep, and it keeps that until the wake pulse arrives. The VDD-fault flag is qualified by that record. The battery-fault pin never starts sleep. Its edges are only recorded, and an edge seen during sleep is shown after wake. Both fault pins pass through a two-flop synchronizer, and only a falling edge counts as an event.

Three outputs drive the GPIO logic: the input-disable flag, the pad-hold flag and a pull-up enable. Hardware reset, watchdog reset and GPIO reset turn the pull-ups on. They go off when software clears the input-disable flag. Entering sleep never turns them back on.

Top module: `slp_status_reg`

## Requirements
- R1: After hardware reset the register reads 0x0000_0020, pull-ups are on, and bits 3 and 31:6 always read zero. The flag positions are: bit0 software sleep, bit1 battery fault, bit2 VDD fault, bit4 pad hold, bit5 input disable.
- R2: Writing 1 to a flag bit clears that bit. Writing 0 leaves it unchanged. Writes to bits 3 and 31:6 have no effect.
- R3: A software sleep request while awake sets bits 0, 4 and 5 in the next cycle.
- R4: A falling edge on `vdd_fault_n` while awake starts sleep and sets bits 4 and 5 but not bit 0. Bit 2 is set at the following wake, and not before it.
- R5: A VDD fault edge during a software-started sleep leaves bit 2 clear, both during sleep and after wake.
- R6: A falling edge on `batt_fault_n` while awake sets bit 1. An edge during sleep does not show until wake, and then sets bit 1.
- R7: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: A `wdt_rst` or `gpio_rst` pulse restores 0x0000_0020, turns the pull-ups on, returns to awake and discards any battery fault pending during sleep.
- R9: `pullup_en` goes low when software clears bit 5. Sleep entry does not raise it again.
- R10: `gpio_in_dis` reflects bit 5 and `pad_hold` reflects bit 4.
- R11: A VDD fault edge and a software request in the same cycle start a fault sleep, so bit 0 stays clear. A software request or a VDD edge during sleep does not change the sleep cause.
- R12: A fault pin held low gives one event only. After software clears the flag, it stays clear while the pin remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_sleep_req | input | 1 | Software sleep start pulse |
| vdd_fault_n | input | 1 | VDD fault pin, active low, asynchronous |
| batt_fault_n | input | 1 | Battery fault pin, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset event pulse |
| gpio_rst | input | 1 | GPIO reset event pulse |
| wake | input | 1 | Wake-up event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data, a one clears the flag |
| reg_rdata | output | 32 | Register read value |
| gpio_in_dis | output | 1 | GPIO input receivers disabled |
| pad_hold | output | 1 | GPIO pads hold their sleep state |
| pullup_en | output | 1 | GPIO pull-ups active |

## Verification
Two things can land on the same flag in the same cycle: a set event from the sleep sequencer, and a software write-1-to-clear. The bench raises a software sleep request on the exact cycle of a clearing write and expects the set to win. A second pairing is the sequencer taking a VDD fault edge and a software request in the same cycle. The bench times the pin drop so that the synchronized edge meets the request pulse, and then checks that only the fault cause is recorded. A sweep over all 64 clear masks, each starting from all flags set, shows that each bit clears independently.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE     = 2'd0,
        ST_SLEEP_SW  = 2'd1,
        ST_SLEEP_VDD = 2'd2
    } slp_state_e;

    localparam int unsigned FLAG_W    = 6;
    localparam int unsigned BIT_SWSLP = 0;
    localparam int unsigned BIT_BATF  = 1;
    localparam int unsigned BIT_VDDF  = 2;
    localparam int unsigned BIT_PHOLD = 4;
    localparam int unsigned BIT_RDIS  = 5;

    localparam logic [FLAG_W-1:0] FLAG_RST_VAL  = 6'b10_0000;
    localparam logic [FLAG_W-1:0] FLAG_IMPL_MSK = 6'b11_0111;

endpackage

// File: rtl/slp_fault_sync.sv
module slp_fault_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin_n};
        end
    end

    assign fall = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_evt,
    input  logic sw_req,
    input  logic vdd_fall,
    input  logic wake,
    output logic enter_sw,
    output logic enter_vdd,
    output logic wake_evt,
    output logic wake_vdd,
    output logic asleep
);

    slp_state_e state_q;
    slp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (rst_evt) begin
            state_d = ST_AWAKE;
        end else begin
            unique case (state_q)
                ST_AWAKE: begin
                    if (vdd_fall) begin
                        state_d = ST_SLEEP_VDD;
                    end else if (sw_req) begin
                        state_d = ST_SLEEP_SW;
                    end
                end
                ST_SLEEP_SW: begin
                    if (wake) begin
                        state_d = ST_AWAKE;
                    end
                end
                ST_SLEEP_VDD: begin
                    if (wake) begin
                        state_d = ST_AWAKE;
                    end
                end
                default: state_d = ST_AWAKE;
            endcase
        end
    end

    always_comb begin
        enter_sw  = 1'b0;
        enter_vdd = 1'b0;
        wake_evt  = 1'b0;
        wake_vdd  = 1'b0;
        asleep    = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                enter_vdd = vdd_fall & ~rst_evt;
                enter_sw  = sw_req & ~vdd_fall & ~rst_evt;
            end
            ST_SLEEP_SW: begin
                asleep   = 1'b1;
                wake_evt = wake & ~rst_evt;
            end
            ST_SLEEP_VDD: begin
                asleep   = 1'b1;
                wake_evt = wake & ~rst_evt;
                wake_vdd = wake & ~rst_evt;
            end
            default: asleep = 1'b0;
        endcase
    end

endmodule

// File: rtl/slp_flags.sv
module slp_flags
    import slp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_evt,
    input  logic              enter_sw,
    input  logic              enter_vdd,
    input  logic              wake_evt,
    input  logic              wake_vdd,
    input  logic              asleep,
    input  logic              batt_fall,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              gpio_in_dis,
    output logic              pad_hold,
    output logic              pullup_en
);

    localparam int unsigned PAD_W = DATA_W - FLAG_W;

    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] flag_d;
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;
    logic              batt_pend_q;
    logic              pull_q;
    logic              sleep_entry;

    assign sleep_entry = enter_sw | enter_vdd;

    always_comb begin
        set_v            = '0;
        set_v[BIT_SWSLP] = enter_sw;
        set_v[BIT_BATF]  = (batt_fall & ~asleep & ~rst_evt)
                         | (wake_evt & (batt_pend_q | batt_fall));
        set_v[BIT_VDDF]  = wake_vdd;
        set_v[BIT_PHOLD] = sleep_entry;
        set_v[BIT_RDIS]  = sleep_entry;
        clr_v            = wr_en ? wr_data[FLAG_W-1:0] : '0;
        flag_d           = (set_v | (flag_q & ~clr_v)) & FLAG_IMPL_MSK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q      <= FLAG_RST_VAL;
            batt_pend_q <= 1'b0;
            pull_q      <= 1'b1;
        end else if (rst_evt) begin
            flag_q      <= FLAG_RST_VAL;
            batt_pend_q <= 1'b0;
            pull_q      <= 1'b1;
        end else begin
            flag_q <= flag_d;
            if (wake_evt) begin
                batt_pend_q <= 1'b0;
            end else if (batt_fall && asleep) begin
                batt_pend_q <= 1'b1;
            end
            if (clr_v[BIT_RDIS] && !set_v[BIT_RDIS]) begin
                pull_q <= 1'b0;
            end
        end
    end

    assign rd_data     = {{PAD_W{1'b0}}, flag_q};
    assign gpio_in_dis = flag_q[BIT_RDIS];
    assign pad_hold    = flag_q[BIT_PHOLD];
    assign pullup_en   = pull_q;

endmodule

// File: rtl/slp_status_reg.sv
module slp_status_reg #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_sleep_req,
    input  logic              vdd_fault_n,
    input  logic              batt_fault_n,
    input  logic              wdt_rst,
    input  logic              gpio_rst,
    input  logic              wake,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              gpio_in_dis,
    output logic              pad_hold,
    output logic              pullup_en
);

    logic rst_evt;
    logic vdd_fall;
    logic batt_fall;
    logic enter_sw;
    logic enter_vdd;
    logic wake_evt;
    logic wake_vdd;
    logic seq_asleep;

    assign rst_evt = wdt_rst | gpio_rst;

    slp_fault_sync #(.STAGES(SYNC_STAGES)) u_vdd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (vdd_fault_n),
        .fall  (vdd_fall)
    );

    slp_fault_sync #(.STAGES(SYNC_STAGES)) u_batt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (batt_fault_n),
        .fall  (batt_fall)
    );

    slp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_evt   (rst_evt),
        .sw_req    (sw_sleep_req),
        .vdd_fall  (vdd_fall),
        .wake      (wake),
        .enter_sw  (enter_sw),
        .enter_vdd (enter_vdd),
        .wake_evt  (wake_evt),
        .wake_vdd  (wake_vdd),
        .asleep    (seq_asleep)
    );

    slp_flags #(.DATA_W(DATA_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_evt     (rst_evt),
        .enter_sw    (enter_sw),
        .enter_vdd   (enter_vdd),
        .wake_evt    (wake_evt),
        .wake_vdd    (wake_vdd),
        .asleep      (seq_asleep),
        .batt_fall   (batt_fall),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .rd_data     (reg_rdata),
        .gpio_in_dis (gpio_in_dis),
        .pad_hold    (pad_hold),
        .pullup_en   (pullup_en)
    );

endmodule

// File: rtl/slp_status_chk.sv
module slp_status_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_rst,
    input logic              gpio_rst,
    input logic              sw_sleep_req,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              gpio_in_dis,
    input logic              pad_hold,
    input logic              pullup_en,
    input logic              asleep
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:6] == '0) && (reg_rdata[3] == 1'b0)); // R1

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst && !gpio_rst && !(reg_wr && (reg_wdata[5:0] != 6'd0)))
        |=> (($past(reg_rdata[5:0]) & ~reg_rdata[5:0]) == 6'd0)); // R2

    AST_SWSLP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[0]) |-> $past(sw_sleep_req)); // R3

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> (gpio_in_dis && pad_hold)); // R10

    AST_VDDF_AT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[2]) |-> $fell(asleep)); // R4

    AST_BATF_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep)) |-> !$rose(reg_rdata[1])); // R6

    AST_RST_EVT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst || gpio_rst) |=> ((reg_rdata == 32'h20) && pullup_en && !asleep)); // R8

    AST_PULLUP_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pullup_en) |-> $past(wdt_rst || gpio_rst)); // R9

endmodule

bind slp_status_reg slp_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_rst      (wdt_rst),
    .gpio_rst     (gpio_rst),
    .sw_sleep_req (sw_sleep_req),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .gpio_in_dis  (gpio_in_dis),
    .pad_hold     (pad_hold),
    .pullup_en    (pullup_en),
    .asleep       (seq_asleep)
);

// File: tb/tb_slp_status_reg.sv
`timescale 1ns/1ps
module tb_slp_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_sleep_req = 1'b0;
    logic        vdd_fault_n = 1'b1;
    logic        batt_fault_n = 1'b1;
    logic        wdt_rst = 1'b0;
    logic        gpio_rst = 1'b0;
    logic        wake = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        gpio_in_dis;
    logic        pad_hold;
    logic        pullup_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    slp_status_reg dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_sleep_req (sw_sleep_req),
        .vdd_fault_n  (vdd_fault_n),
        .batt_fault_n (batt_fault_n),
        .wdt_rst      (wdt_rst),
        .gpio_rst     (gpio_rst),
        .wake         (wake),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .gpio_in_dis  (gpio_in_dis),
        .pad_hold     (pad_hold),
        .pullup_en    (pullup_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_sleep_req = 1'b1;
        @(negedge clk); sw_sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic set_vdd(input logic v);
        @(negedge clk); vdd_fault_n = v;
        idle(4);
    endtask

    task automatic set_batt(input logic v);
        @(negedge clk); batt_fault_n = v;
        idle(4);
    endtask

    task automatic fill_all();
        set_batt(1'b0); set_batt(1'b1);
        set_vdd(1'b0);  set_vdd(1'b1);
        pulse_wake();
        pulse_sw();
        pulse_wake();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state, R10 outputs
        chk("R1 reset value", reg_rdata, 32'h20);
        chk("R1 pullup after reset", {31'b0, pullup_en}, 32'd1);
        chk("R10 gpio_in_dis", {31'b0, gpio_in_dis}, 32'd1);
        chk("R10 pad_hold", {31'b0, pad_hold}, 32'd0);

        // R2 zero write and reserved write
        wr(32'h0);
        chk("R2 write zero", reg_rdata, 32'h20);
        wr(32'hFFFF_FFC8);
        chk("R2 reserved write", reg_rdata, 32'h20);

        // R9 clearing input disable drops pullups
        wr(32'h20);
        chk("R9 rdis cleared", reg_rdata, 32'h0);
        chk("R9 pullup off", {31'b0, pullup_en}, 32'd0);
        chk("R10 gpio_in_dis low", {31'b0, gpio_in_dis}, 32'd0);

        // R3 software sleep
        pulse_sw();
        chk("R3 sw sleep flags", reg_rdata, 32'h31);
        chk("R10 pad_hold set", {31'b0, pad_hold}, 32'd1);
        chk("R9 no pullup rearm", {31'b0, pullup_en}, 32'd0);

        // R5 VDD fault during sw sleep
        set_vdd(1'b0);
        chk("R5 during sleep", reg_rdata, 32'h31);
        pulse_wake();
        chk("R5 after wake", reg_rdata, 32'h31);
        set_vdd(1'b1);
        wr(32'h37);
        chk("R2 clear all", reg_rdata, 32'h0);

        // R4 fault-started sleep, R11 sw request ignored while asleep
        set_vdd(1'b0);
        chk("R4 fault sleep before wake", reg_rdata, 32'h30);
        pulse_sw();
        chk("R11 sw while asleep", reg_rdata, 32'h30);
        pulse_wake();
        chk("R4 vddf at wake", reg_rdata, 32'h34);
        pulse_wake();
        chk("R11 wake while awake", reg_rdata, 32'h34);
        set_vdd(1'b1);
        wr(32'h37);

        // R6 battery fault awake, R12 held pin
        set_batt(1'b0);
        chk("R6 batf awake", reg_rdata, 32'h02);
        wr(32'h02);
        idle(4);
        chk("R12 held low no repeat", reg_rdata, 32'h0);
        set_batt(1'b1);

        // R6 battery fault while asleep
        pulse_sw();
        set_batt(1'b0);
        chk("R6 batf hidden asleep", reg_rdata, 32'h31);
        pulse_wake();
        chk("R6 batf at wake", reg_rdata, 32'h33);
        set_batt(1'b1);
        wr(32'h37);

        // R7 set beats clear in same cycle
        @(negedge clk);
        sw_sleep_req = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h31;
        @(negedge clk);
        sw_sleep_req = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk("R7 set wins", reg_rdata, 32'h31);
        pulse_wake();
        wr(32'h37);

        // R11 VDD edge and sw request in the same cycle
        @(negedge clk); vdd_fault_n = 1'b0;
        @(negedge clk);
        @(negedge clk); sw_sleep_req = 1'b1;
        @(negedge clk); sw_sleep_req = 1'b0;
        chk("R11 fault wins", reg_rdata, 32'h30);
        pulse_wake();
        chk("R11 after wake", reg_rdata, 32'h34);
        set_vdd(1'b1);

        // R8 reset events, pending battery fault discarded
        for (int k = 0; k < 2; k++) begin
            wr(32'h37);
            pulse_sw();
            set_batt(1'b0);
            @(negedge clk);
            if (k == 0) wdt_rst = 1'b1; else gpio_rst = 1'b1;
            @(negedge clk);
            wdt_rst = 1'b0; gpio_rst = 1'b0;
            chk("R8 reset event value", reg_rdata, 32'h20);
            chk("R8 pullup on", {31'b0, pullup_en}, 32'd1);
            pulse_wake();
            chk("R8 pending dropped", reg_rdata, 32'h20);
            set_batt(1'b1);
        end

        // R2 sweep of all clear masks from all flags set
        for (int m = 0; m < 64; m++) begin
            fill_all();
            chk("R2 fill", reg_rdata, 32'h37);
            wr({26'h2AA_AAAA ^ 26'(m), 6'(m)});
            chk("R2 mask sweep", reg_rdata, 32'h37 & ~32'(m));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule